// File: doc/BRIEF.md
# Multi-Core Debug Run Control

This block lets debug software stop, resume and single-step up to sixteen processor cores through three 32-bit control words on a small register bus. Each core has one state flop that records whether the core is running or halted. The core sees that state as a level (`core_halt`). It also receives a one-cycle `core_step` pulse whenever software asks a halted core to execute exactly one instruction.

A core can be halted in two ways: software sets its bit in the halt word, or the core itself reports an executed breakpoint instruction on `brk_hit`. Both requests are handled the same way. A core reports that it is in its uncancellable thread-end cleanup on `cleanup_busy`. While that signal is high, a halt request is not applied but kept pending. It is applied in the cycle after cleanup ends. A halted core is not affected by thread boundaries, so a core stopped by a breakpoint stays stopped when a new thread starts on it, until software resumes it.

Read data is combinational from the state flops. Every request takes effect at the next clock edge.

Top module: `core_run_ctrl`

## Requirements
- R1: After reset every core is running. The run word reads 0x0000FFFF, the halt word reads 0x00000000, and `core_halt` and `core_step` are all 0.
- R2: Register offsets are run word at 0x0, halt word at 0x4 and step word at 0x8. Bit i of each word belongs to core i. Bits 31:16 always read 0. The step word and every other offset read 0.
- R3: Writing 1 to halt bit i of a running core that is not in cleanup sets `core_halt[i]` from the next cycle. From then on, halt bit i reads 1 and run bit i reads 0.
- R4: Writing 1 to run bit i of a halted core clears `core_halt[i]` from the next cycle. Run bit i then reads 1 again.
- R5: Zero bits in any write change nothing. A run write to a running core changes nothing. A halt write to an already halted core changes nothing.
- R6: Writing 1 to step bit i of a halted core raises `core_step[i]` for exactly the one cycle after the write, and the core stays halted. A step write to a running core produces no pulse.
- R7: A `brk_hit[i]` pulse on a running core outside cleanup halts it from the next cycle, exactly like a halt write.
- R8: A halt write or breakpoint while `cleanup_busy[i]` is high leaves the core running for as long as cleanup lasts. The halt is held pending and `core_halt[i]` rises in the cycle after the first cycle with `cleanup_busy[i]` low.
- R9: A halted core stays halted through any activity on `cleanup_busy[i]`, including a full cleanup and the start of a new thread. Only a run write releases it.
- R10: When a breakpoint pulse and a run write for the same core fall in the same cycle, the halt wins: the core is halted afterwards, whatever state it was in before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the accessed word |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| brk_hit | input | 16 | Per-core breakpoint-executed pulse |
| cleanup_busy | input | 16 | Per-core thread-end cleanup in progress |
| core_halt | output | 16 | Per-core halt level to the core |
| core_step | output | 16 | Per-core single-instruction advance pulse |

## Verification
Every state change is due one clock edge after the write or breakpoint that requests it. The step pulse is due in the cycle after the step write and must be gone one cycle later. A deferred halt is due one edge after the first cycle in which cleanup is low. The bench drives inputs and samples outputs at the falling edge, so each check lands in the cycle counted from those latencies. The bench also samples the cycles just before each change is due, which confirms that nothing changes early.

// File: rtl/core_dbg_pkg.sv
// Shared constants and types for the multi-core debug run controller.
// Assumes byte offsets on the register bus; only the listed offsets decode.
package core_dbg_pkg;
    localparam int unsigned OFS_RUN  = 0;
    localparam int unsigned OFS_HALT = 4;
    localparam int unsigned OFS_STEP = 8;

    // Which control word the current bus address selects.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_RUN  = 2'd1,
        SEL_HALT = 2'd2,
        SEL_STEP = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/core_dbg_decode.sv
// Address decoder: turns a bus access into the selected word and into
// per-core write-one strobes for the run, halt and step words.
// Assumes one access per cycle; zero bits in write data produce no strobe.
module core_dbg_decode
    import core_dbg_pkg::*;
#(
    parameter int N_CORES = 16,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output reg_sel_e           sel,
    output logic [N_CORES-1:0] set_run,
    output logic [N_CORES-1:0] set_halt,
    output logic [N_CORES-1:0] set_step
);
    logic [N_CORES-1:0] wbits;

    assign wbits = bus_wdata[N_CORES-1:0];

    // Map the byte offset onto one of the three control words.
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_RUN):  sel = SEL_RUN;
            ADDR_W'(OFS_HALT): sel = SEL_HALT;
            ADDR_W'(OFS_STEP): sel = SEL_STEP;
            default:           sel = SEL_NONE;
        endcase
    end

    // Qualify the written ones with the strobe and the selected word.
    always_comb begin
        set_run  = '0;
        set_halt = '0;
        set_step = '0;
        if (bus_wr) begin
            case (sel)
                SEL_RUN:  set_run  = wbits;
                SEL_HALT: set_halt = wbits;
                SEL_STEP: set_step = wbits;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/core_dbg_lane.sv
// Run control for one core: a single state flop (1 = halted), a pending
// flag for halts that arrive during thread-end cleanup, and a step pulse.
// Assumes req_halt already merges software halts and breakpoint pulses.
module core_dbg_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic req_halt,
    input  logic req_run,
    input  logic req_step,
    input  logic busy,
    output logic halted,
    output logic step_pulse
);
    logic pend_q;

    // Next halted state: halt beats run, and cleanup defers halts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
            pend_q <= 1'b0;
        end else if (halted) begin
            if (req_run && !req_halt) begin
                halted <= 1'b0;
            end
        end else if (busy) begin
            if (req_halt) begin
                pend_q <= 1'b1;
            end
        end else if (req_halt || pend_q) begin
            halted <= 1'b1;
            pend_q <= 1'b0;
        end
    end

    // Advance pulse: one cycle, only for a core that is halted now.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_pulse <= 1'b0;
        end else begin
            step_pulse <= halted && req_step;
        end
    end
endmodule

// File: rtl/core_dbg_readmux.sv
// Read path: presents run (inverted state) or halt (state) in the low
// bits; the step word, reserved bits and unused offsets read zero.
module core_dbg_readmux
    import core_dbg_pkg::*;
#(
    parameter int N_CORES = 16,
    parameter int DATA_W  = 32
) (
    input  reg_sel_e           sel,
    input  logic [N_CORES-1:0] halted,
    output logic [DATA_W-1:0]  rdata
);
    // Select the view of the state flops for the addressed word.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_RUN:  rdata[N_CORES-1:0] = ~halted;
            SEL_HALT: rdata[N_CORES-1:0] = halted;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/core_run_ctrl.sv
// Top of the multi-core debug run controller. Decodes the register bus,
// merges software halts with breakpoint pulses, and runs one lane per core.
// Assumes N_CORES <= DATA_W and that brk_hit is a one-cycle pulse.
module core_run_ctrl
    import core_dbg_pkg::*;
#(
    parameter int N_CORES = 16,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [N_CORES-1:0] brk_hit,
    input  logic [N_CORES-1:0] cleanup_busy,
    output logic [N_CORES-1:0] core_halt,
    output logic [N_CORES-1:0] core_step
);
    reg_sel_e           sel;
    logic [N_CORES-1:0] set_run;
    logic [N_CORES-1:0] set_halt;
    logic [N_CORES-1:0] set_step;
    logic [N_CORES-1:0] halt_req;

    core_dbg_decode #(
        .N_CORES(N_CORES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .sel      (sel),
        .set_run  (set_run),
        .set_halt (set_halt),
        .set_step (set_step)
    );

    // A breakpoint counts exactly like a software halt write.
    assign halt_req = set_halt | brk_hit;

    for (genvar i = 0; i < N_CORES; i++) begin : g_lane
        core_dbg_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_halt  (halt_req[i]),
            .req_run   (set_run[i]),
            .req_step  (set_step[i]),
            .busy      (cleanup_busy[i]),
            .halted    (core_halt[i]),
            .step_pulse(core_step[i])
        );
    end

    core_dbg_readmux #(
        .N_CORES(N_CORES), .DATA_W(DATA_W)
    ) u_readmux (
        .sel   (sel),
        .halted(core_halt),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/core_run_ctrl_chk.sv
// Protocol checker for core_run_ctrl, attached by bind. Watches only ports.
module core_run_ctrl_chk
    import core_dbg_pkg::*;
#(
    parameter int N_CORES = 16,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [N_CORES-1:0] brk_hit,
    input logic [N_CORES-1:0] cleanup_busy,
    input logic [N_CORES-1:0] core_halt,
    input logic [N_CORES-1:0] core_step
);
    logic wr_run, wr_halt, wr_step;
    assign wr_run  = bus_wr && (bus_addr == ADDR_W'(OFS_RUN));
    assign wr_halt = bus_wr && (bus_addr == ADDR_W'(OFS_HALT));
    assign wr_step = bus_wr && (bus_addr == ADDR_W'(OFS_STEP));

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (core_halt == '0 && core_step == '0));

    if (N_CORES < DATA_W) begin : g_rsv
        p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rdata[DATA_W-1:N_CORES] == '0);
    end

    p_step_word_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_STEP)) |-> bus_rdata == '0);

    for (genvar i = 0; i < N_CORES; i++) begin : g_core
        p_halt_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_halt && bus_wdata[i] && !cleanup_busy[i]) |=> core_halt[i]);

        p_run_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_run && bus_wdata[i] && core_halt[i] && !brk_hit[i]) |=> !core_halt[i]);

        p_step_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
            core_step[i] |-> ($past(core_halt[i]) && core_halt[i]));

        p_step_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
            core_step[i] |-> $past(wr_step && bus_wdata[i]));

        p_brk_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (brk_hit[i] && !cleanup_busy[i]) |=> core_halt[i]);

        p_cleanup_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cleanup_busy[i] && !core_halt[i]) |=> !core_halt[i]);

        p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (core_halt[i] && !(wr_run && bus_wdata[i])) |=> core_halt[i]);

        p_halt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (brk_hit[i] && wr_run && bus_wdata[i] && (core_halt[i] || !cleanup_busy[i]))
            |=> core_halt[i]);
    end
endmodule

bind core_run_ctrl core_run_ctrl_chk #(
    .N_CORES(N_CORES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/core_run_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench for core_run_ctrl: one task per scenario, each self-checking.
module core_run_ctrl_bench;
    localparam int N = 16;
    localparam logic [3:0] A_RUN = 4'h0, A_HALT = 4'h4, A_STEP = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] brk_hit = '0;
    logic [N-1:0] cleanup_busy = '0;
    logic [N-1:0] core_halt;
    logic [N-1:0] core_step;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    core_run_ctrl u_core_run_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .brk_hit(brk_hit),
        .cleanup_busy(cleanup_busy), .core_halt(core_halt), .core_step(core_step)
    );

    // Compare one value and report a mismatch.
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One-cycle write; returns at the falling edge after the capturing edge.
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        #0.5;
    endtask

    // Combinational read at the current falling edge region.
    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    // Return every core to running with a run write of all ones.
    task automatic release_all();
        bus_write(A_RUN, 32'h0000_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(A_RUN, d);  check("R1 run word after reset", d, 32'h0000_FFFF);
        bus_read(A_HALT, d); check("R1 halt word after reset", d, 32'h0);
        check("R1 core_halt after reset", 32'(core_halt), 32'h0);
        check("R1 core_step after reset", 32'(core_step), 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        bus_write(A_HALT, 32'hFFFF_0005);
        bus_read(A_HALT, d); check("R2 halt word reserved bits zero", d, 32'h0000_0005);
        bus_read(A_RUN, d);  check("R2 run word reserved bits zero", d, 32'h0000_FFFA);
        bus_read(A_STEP, d); check("R2 step word reads zero", d, 32'h0);
        bus_read(4'hC, d);   check("R2 unused offset reads zero", d, 32'h0);
        release_all();
    endtask

    task automatic t_halt_write();
        logic [31:0] d;
        @(negedge clk);
        bus_addr = A_HALT; bus_wdata = 32'h0000_8000; bus_wr = 1'b1;
        #0.5;
        check("R3 no halt before edge", 32'(core_halt), 32'h0);
        @(negedge clk);
        bus_wr = 1'b0; #0.5;
        check("R3 core_halt after halt write", 32'(core_halt), 32'h0000_8000);
        bus_read(A_HALT, d); check("R3 halt bit reads 1", d, 32'h0000_8000);
        bus_read(A_RUN, d);  check("R3 run bit reads 0", d, 32'h0000_7FFF);
    endtask

    task automatic t_run_write();
        logic [31:0] d;
        bus_write(A_RUN, 32'h0000_8000);
        check("R4 core resumes after run write", 32'(core_halt), 32'h0);
        bus_read(A_RUN, d); check("R4 run word all ones again", d, 32'h0000_FFFF);
    endtask

    task automatic t_ignore();
        bus_write(A_HALT, 32'h0000_0003);
        bus_write(A_HALT, 32'h0000_0000);
        bus_write(A_RUN, 32'h0000_0000);
        check("R5 zero writes change nothing", 32'(core_halt), 32'h0000_0003);
        bus_write(A_RUN, 32'h0000_0004);
        check("R5 run write to running core ignored", 32'(core_halt), 32'h0000_0003);
        bus_write(A_HALT, 32'h0000_0001);
        check("R5 halt write to halted core ignored", 32'(core_halt), 32'h0000_0003);
        release_all();
    endtask

    task automatic t_step();
        bus_write(A_HALT, 32'h0000_0010);
        bus_write(A_STEP, 32'h0000_0030);
        check("R6 step pulse only on halted core", 32'(core_step), 32'h0000_0010);
        check("R6 core stays halted during step", 32'(core_halt), 32'h0000_0010);
        @(negedge clk); #0.5;
        check("R6 step pulse lasts one cycle", 32'(core_step), 32'h0);
        check("R6 core halted after step", 32'(core_halt), 32'h0000_0010);
        release_all();
    endtask

    task automatic t_brk();
        @(negedge clk);
        brk_hit = 16'h0200;
        @(negedge clk);
        brk_hit = '0; #0.5;
        check("R7 breakpoint halts core", 32'(core_halt), 32'h0000_0200);
        release_all();
    endtask

    task automatic t_cleanup();
        @(negedge clk);
        cleanup_busy = 16'h0040;
        bus_write(A_HALT, 32'h0000_0040);
        check("R8 halt deferred during cleanup", 32'(core_halt), 32'h0);
        @(negedge clk); brk_hit = 16'h0040;
        @(negedge clk); brk_hit = '0; #0.5;
        check("R8 still running while busy", 32'(core_halt), 32'h0);
        cleanup_busy = '0; #0.5;
        check("R8 not halted in last busy edge", 32'(core_halt), 32'h0);
        @(negedge clk); #0.5;
        check("R8 pending halt applied after cleanup", 32'(core_halt), 32'h0000_0040);
        release_all();
    endtask

    task automatic t_persist();
        @(negedge clk); brk_hit = 16'h0001;
        @(negedge clk); brk_hit = '0;
        cleanup_busy = 16'h0001;
        repeat (3) @(negedge clk);
        cleanup_busy = '0;
        repeat (3) @(negedge clk);
        #0.5;
        check("R9 halt persists across thread end", 32'(core_halt), 32'h0000_0001);
        release_all();
        check("R9 run write releases core", 32'(core_halt), 32'h0);
    endtask

    task automatic t_priority();
        @(negedge clk);
        brk_hit = 16'h0100;
        bus_addr = A_RUN; bus_wdata = 32'h0000_0100; bus_wr = 1'b1;
        @(negedge clk);
        brk_hit = '0; bus_wr = 1'b0; #0.5;
        check("R10 halt wins over run on running core", 32'(core_halt), 32'h0000_0100);
        @(negedge clk);
        brk_hit = 16'h0100;
        bus_addr = A_RUN; bus_wdata = 32'h0000_0100; bus_wr = 1'b1;
        @(negedge clk);
        brk_hit = '0; bus_wr = 1'b0; #0.5;
        check("R10 halt wins over run on halted core", 32'(core_halt), 32'h0000_0100);
        release_all();
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_halt_write();
        t_run_write();
        t_ignore();
        t_step();
        t_brk();
        t_cleanup();
        t_persist();
        t_priority();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule